// File: doc/BRIEF.md
# Reset Source and Start-up Timer Controller

This block decides which reset or wake-up source acts on a small processor core, and when the core may run again. It watches a power-good level, a brown-out level, the active-low master-clear pin, a watchdog expiry pulse and an interrupt wake request. Each event is ranked by priority and recorded in a four-bit sticky status word. The block then holds the core while a power-up timer and an oscillator start-up counter run down. It also tells the core where to resume: at the reset vector, at the next instruction, or at the next instruction followed by the interrupt routine.

The wait depends on both the cause and the oscillator mode. Power-on and brown-out always wait for the longer of the power-up timer and the start-up count. Events that leave sleep wait for the start-up count only when a crystal mode is selected. Master-clear and watchdog resets taken while the core is running release it with no wait. Firmware may overwrite the status word and may strobe a watchdog clear while the core is not held.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `core_hold` is 1, `status` is 4'b0011 and `vec_sel` is 2'b00. `status` is ordered {POR, BOR, TO, PD} from bit 3 down to bit 0.
- R2: While `por_good` is 0, `core_hold` stays 1 and `status` is 0011. After power and master-clear are both good, `core_hold` stays high for exactly max(PWR_CYC, OSC_CYC) cycles and `vec_sel` is 00, where 00 selects the reset vector.
- R3: While `mclr_n` is low after power-on, the timers do not start. The timed wait starts at the first rising edge of `mclr_n`. A master-clear asserted during a power-on or brown-out sequence leaves `status` unchanged.
- R4: While `por_good` is 1, `bor_det` high gives status 1011 and the same wait as R2. A brown-out that arrives during a running wait restarts the full wait.
- R5: Priority is power-on, then brown-out, then master-clear, then watchdog. Power-on and brown-out together give 0011. Brown-out with master-clear gives 1011. Master-clear with watchdog in run gives 1111.
- R6: Master-clear while running gives status 1111 and `vec_sel` 00. After `mclr_n` rises, the core is held for exactly 1 cycle.
- R7: A watchdog pulse while running gives status 1101 and `vec_sel` 00. The core is held for 2 cycles from the cycle after the pulse: one cycle to arm and one cycle of wait.
- R8: Events that leave sleep wait OSC_CYC cycles in crystal modes (`osc_mode` 00 or 01) and 1 cycle in the external-clock and RC modes (10, 11). A watchdog during sleep gives status 1100 and `vec_sel` 00. A master-clear during sleep gives status 1110.
- R9: An interrupt wake from sleep gives status 1110. It gives `vec_sel` 01 (next instruction) when `gie_dis` is 1, and 10 (next instruction, then the interrupt vector) when `gie_dis` is 0. `vec_sel` is never 11. A wake request while running changes no output.
- R10: A `clr_wdt` strobe while the core is not held sets TO and PD to 1 and keeps POR and BOR.
- R11: `flag_we` loads `flag_wdata` into `status` while the core is not held. While `core_hold` is 1, the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset of the block; behaves as a power-on |
| por_good | input | 1 | Power-on detector level, 1 once supply is above trip point |
| bor_det | input | 1 | Brown-out detector level, 1 while supply is low |
| mclr_n | input | 1 | Master-clear pin, active low |
| wdt_expire | input | 1 | Watchdog expiry pulse |
| sleep_req | input | 1 | Core has entered sleep |
| wake_req | input | 1 | Interrupt wake request |
| gie_dis | input | 1 | Global interrupt disable bit of the core |
| osc_mode | input | 2 | 00/01 crystal modes, 10 external clock, 11 RC |
| clr_wdt | input | 1 | Watchdog clear strobe |
| flag_we | input | 1 | Firmware write strobe for the status word |
| flag_wdata | input | 4 | Firmware write data {POR,BOR,TO,PD} |
| core_hold | output | 1 | Registered hold/stall to the core, active high |
| vec_sel | output | 2 | Resume point: 00 reset vector, 01 next instruction, 10 next then interrupt |
| status | output | 4 | Sticky status {POR,BOR,TO,PD} |

## Verification
The hardest case to reach is a brown-out that lands in the middle of a running wait. Doing so requires the core to be held and the timer part-way down, which the ports show only as a steady `core_hold`. The stimulus releases a brown-out, counts fifty cycles into the wait, and pulses brown-out again. It then measures the full hold length. A restart that failed would end about fifty cycles early. Priority is reached the same way: the competing sources are driven in the same cycle from a known running state.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {ST_ARM, ST_TIME, ST_RUN, ST_SLEEP} seq_state_e;
  typedef enum logic [1:0] {VEC_RESET = 2'b00, VEC_NEXT = 2'b01, VEC_NEXT_INT = 2'b10} vec_sel_e;

  // {POR, BOR, TO, PD}
  localparam logic [3:0] FL_POWER   = 4'b0011;
  localparam logic [3:0] FL_BROWN   = 4'b1011;
  localparam logic [3:0] FL_MC_RUN  = 4'b1111;
  localparam logic [3:0] FL_SLP_WK  = 4'b1110;
  localparam logic [3:0] FL_WD_RUN  = 4'b1101;
  localparam logic [3:0] FL_WD_SLP  = 4'b1100;

  typedef struct packed {
    logic       fire;        // a new event: load flags, vector, timer needs
    logic       stall_only;  // master-clear low inside a sequence: re-arm only
    logic [3:0] flags;
    vec_sel_e   vec;
    logic       need_pwr;
    logic       need_osc;
  } rst_evt_t;
endpackage

// File: rtl/rst_src_arb.sv
module rst_src_arb
  import rst_seq_pkg::*;
(
  input  logic       por_good,
  input  logic       bor_det,
  input  logic       mclr_n,
  input  logic       wdt_expire,
  input  logic       wake_req,
  input  logic       gie_dis,
  input  logic       crystal,
  input  seq_state_e state,
  output rst_evt_t   evt
);
  logic running, sleeping;
  assign running  = (state == ST_RUN);
  assign sleeping = (state == ST_SLEEP);

  always_comb begin
    evt = '0;
    evt.vec = VEC_RESET;
    if (!por_good) begin
      evt.fire = 1'b1; evt.flags = FL_POWER;
      evt.need_pwr = 1'b1; evt.need_osc = 1'b1;
    end else if (bor_det) begin
      evt.fire = 1'b1; evt.flags = FL_BROWN;
      evt.need_pwr = 1'b1; evt.need_osc = 1'b1;
    end else if (!mclr_n) begin
      if (running) begin
        evt.fire = 1'b1; evt.flags = FL_MC_RUN;
      end else if (sleeping) begin
        evt.fire = 1'b1; evt.flags = FL_SLP_WK; evt.need_osc = crystal;
      end else begin
        evt.stall_only = 1'b1;
      end
    end else if (wdt_expire && running) begin
      evt.fire = 1'b1; evt.flags = FL_WD_RUN;
    end else if (wdt_expire && sleeping) begin
      evt.fire = 1'b1; evt.flags = FL_WD_SLP; evt.need_osc = crystal;
    end else if (wake_req && sleeping) begin
      evt.fire = 1'b1; evt.flags = FL_SLP_WK; evt.need_osc = crystal;
      evt.vec = gie_dis ? VEC_NEXT : VEC_NEXT_INT;
    end
  end
endmodule

// File: rtl/rst_dly_cnt.sv
module rst_dly_cnt #(
  parameter int LEN = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic need,
  input  logic en,
  output logic done
);
  localparam int W = $clog2(LEN + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= need ? W'(LEN) : '0;
    end else if (en && cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  // Last counting cycle is the one with value 1 (or an empty wait)
  assign done = (cnt <= W'(1));
endmodule

// File: rtl/rst_flag_reg.sv
module rst_flag_reg
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       evt_fire,
  input  logic [3:0] evt_flags,
  input  logic       sw_ok,
  input  logic       sw_we,
  input  logic [3:0] sw_data,
  input  logic       wd_clear,
  output logic [3:0] flags
);
  logic [3:0] nxt;

  always_comb begin
    nxt = flags;
    if (evt_fire) begin
      nxt = evt_flags;
    end else if (sw_ok) begin
      if (sw_we)    nxt = sw_data;
      if (wd_clear) nxt[1:0] = 2'b11;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= FL_POWER;
    else     flags <= nxt;
  end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int PWR_CYC = 24000,
  parameter int OSC_CYC = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       por_good,
  input  logic       bor_det,
  input  logic       mclr_n,
  input  logic       wdt_expire,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       gie_dis,
  input  logic [1:0] osc_mode,
  input  logic       clr_wdt,
  input  logic       flag_we,
  input  logic [3:0] flag_wdata,
  output logic       core_hold,
  output logic [1:0] vec_sel,
  output logic [3:0] status
);
  seq_state_e state, nxt;
  rst_evt_t   evt;
  logic       need_pwr_q, need_osc_q;
  logic       load, pwr_done, osc_done, timing;
  vec_sel_e   vec_q;

  rst_src_arb u_arb (
    .por_good   (por_good),
    .bor_det    (bor_det),
    .mclr_n     (mclr_n),
    .wdt_expire (wdt_expire),
    .wake_req   (wake_req),
    .gie_dis    (gie_dis),
    .crystal    (~osc_mode[1]),
    .state      (state),
    .evt        (evt)
  );

  assign timing = (state == ST_TIME);

  rst_dly_cnt #(.LEN(PWR_CYC)) u_pwr_tmr (
    .clk(clk), .rst(rst), .load(load), .need(need_pwr_q), .en(timing), .done(pwr_done)
  );

  rst_dly_cnt #(.LEN(OSC_CYC)) u_osc_tmr (
    .clk(clk), .rst(rst), .load(load), .need(need_osc_q), .en(timing), .done(osc_done)
  );

  rst_flag_reg u_flags (
    .clk       (clk),
    .rst       (rst),
    .evt_fire  (evt.fire),
    .evt_flags (evt.flags),
    .sw_ok     (~core_hold),
    .sw_we     (flag_we),
    .sw_data   (flag_wdata),
    .wd_clear  (clr_wdt),
    .flags     (status)
  );

  always_comb begin
    nxt  = state;
    load = 1'b0;
    if (evt.fire || evt.stall_only) begin
      nxt = ST_ARM;
    end else begin
      unique case (state)
        ST_ARM:   begin nxt = ST_TIME; load = 1'b1; end
        ST_TIME:  if (pwr_done && osc_done) nxt = ST_RUN;
        ST_RUN:   if (sleep_req) nxt = ST_SLEEP;
        ST_SLEEP: nxt = ST_SLEEP;
        default:  nxt = ST_ARM;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_ARM;
      core_hold  <= 1'b1;
      vec_q      <= VEC_RESET;
      need_pwr_q <= 1'b1;
      need_osc_q <= 1'b1;
    end else begin
      state     <= nxt;
      core_hold <= (nxt == ST_ARM) || (nxt == ST_TIME);
      if (evt.fire) begin
        vec_q      <= evt.vec;
        need_pwr_q <= evt.need_pwr;
        need_osc_q <= evt.need_osc;
      end
    end
  end

  assign vec_sel = vec_q;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       por_good,
  input logic       bor_det,
  input logic       mclr_n,
  input logic       wdt_expire,
  input logic       wake_req,
  input logic       clr_wdt,
  input logic       flag_we,
  input logic       core_hold,
  input logic [1:0] vec_sel,
  input logic [3:0] status
);
  p_power_low_r2: assert property (@(posedge clk) disable iff (rst)
    !por_good |=> core_hold && status == 4'b0011);

  p_brown_flags_r4: assert property (@(posedge clk) disable iff (rst)
    por_good && bor_det |=> core_hold && status == 4'b1011);

  p_mclr_holds_r3: assert property (@(posedge clk) disable iff (rst)
    !mclr_n |=> core_hold);

  p_release_clean_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(core_hold) |-> $past(mclr_n) && $past(por_good) && !$past(bor_det));

  p_vec_legal_r9: assert property (@(posedge clk) disable iff (rst)
    vec_sel != 2'b11);

  p_wd_clear_r10: assert property (@(posedge clk) disable iff (rst)
    por_good && !bor_det && mclr_n && !wdt_expire && !wake_req && !core_hold
      && clr_wdt && !flag_we |=> status[1:0] == 2'b11 && $stable(status[3:2]));
endmodule

bind rst_seq_ctrl rst_seq_chk u_chk (.*);

// File: tb/tb_rst_seq_ctrl.sv
module tb_rst_seq_ctrl;
  localparam int PWR = 100;
  localparam int OSC = 64;

  logic clk = 1'b0;
  logic rst, por_good, bor_det, mclr_n, wdt_expire, sleep_req, wake_req;
  logic gie_dis, clr_wdt, flag_we;
  logic [1:0] osc_mode;
  logic [3:0] flag_wdata;
  logic core_hold;
  logic [1:0] vec_sel;
  logic [3:0] status;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  rst_seq_ctrl #(.PWR_CYC(PWR), .OSC_CYC(OSC)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic count_hold(output int n);
    n = 0;
    while (core_hold === 1'b1 && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_power_on;
    int n;
    rst = 1; por_good = 0; bor_det = 0; mclr_n = 0; wdt_expire = 0;
    sleep_req = 0; wake_req = 0; gie_dis = 0; clr_wdt = 0; flag_we = 0;
    flag_wdata = 0; osc_mode = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1 hold", core_hold, 1); chk("R1 status", status, 4'b0011); chk("R1 vec", vec_sel, 0);
    rst = 0;
    @(negedge clk);
    chk("R2 por low hold", core_hold, 1); chk("R2 por low status", status, 4'b0011);
    por_good = 1;
    repeat (20) @(negedge clk);
    chk("R3 mclr low keeps hold", core_hold, 1);
    mclr_n = 1;
    @(negedge clk);
    count_hold(n);
    chk("R2 power-on wait", n, PWR);
    chk("R2 vec", vec_sel, 0);
  endtask

  task automatic enter_sleep;
    sleep_req = 1;
    @(negedge clk);
    chk("R8 sleep no hold", core_hold, 0);
  endtask

  task automatic t_wake(input logic [1:0] mode, input logic gie, input logic [1:0] exp_vec, input int len);
    int n;
    osc_mode = mode; gie_dis = gie;
    enter_sleep();
    sleep_req = 0; wake_req = 1;
    @(negedge clk);
    wake_req = 0;
    chk("R9 wake status", status, 4'b1110); chk("R9 wake vec", vec_sel, exp_vec);
    count_hold(n);
    chk("R8 wake wait", n, 1 + len);
  endtask

  task automatic t_mclr_run;
    int n;
    mclr_n = 0;
    @(negedge clk);
    chk("R6 status", status, 4'b1111); chk("R6 vec", vec_sel, 0); chk("R6 hold", core_hold, 1);
    mclr_n = 1;
    @(negedge clk);
    count_hold(n);
    chk("R6 wait", n, 1);
  endtask

  task automatic t_wdt_run;
    int n;
    wdt_expire = 1;
    @(negedge clk);
    wdt_expire = 0;
    chk("R7 status", status, 4'b1101); chk("R7 vec", vec_sel, 0);
    count_hold(n);
    chk("R7 wait", n, 2);
  endtask

  task automatic t_wdt_sleep(input logic [1:0] mode, input int len);
    int n;
    osc_mode = mode;
    enter_sleep();
    sleep_req = 0; wdt_expire = 1;
    @(negedge clk);
    wdt_expire = 0;
    chk("R8 wdt sleep status", status, 4'b1100); chk("R8 wdt sleep vec", vec_sel, 0);
    count_hold(n);
    chk("R8 wdt sleep wait", n, 1 + len);
  endtask

  task automatic t_mclr_sleep(input logic [1:0] mode, input int len);
    int n;
    osc_mode = mode;
    enter_sleep();
    sleep_req = 0; mclr_n = 0;
    @(negedge clk);
    chk("R8 mclr sleep status", status, 4'b1110); chk("R8 mclr sleep hold", core_hold, 1);
    repeat (3) @(negedge clk);
    mclr_n = 1;
    @(negedge clk);
    count_hold(n);
    chk("R8 mclr sleep wait", n, len);
  endtask

  task automatic t_wake_ignored;
    gie_dis = 0; wake_req = 1;
    @(negedge clk);
    wake_req = 0;
    @(negedge clk);
    chk("R9 run wake hold", core_hold, 0);
    chk("R9 run wake status", status, 4'b1110);
    chk("R9 run wake vec", vec_sel, 0);
  endtask

  task automatic t_brownout;
    int n;
    bor_det = 1;
    repeat (3) @(negedge clk);
    chk("R4 bor status", status, 4'b1011);
    bor_det = 0;
    count_hold(n);
    chk("R4 bor wait", n, 1 + PWR);
  endtask

  task automatic t_bor_restart;
    int n;
    bor_det = 1;
    @(negedge clk);
    bor_det = 0;
    repeat (50) @(negedge clk);
    chk("R4 still held mid-wait", core_hold, 1);
    bor_det = 1;
    @(negedge clk);
    bor_det = 0;
    count_hold(n);
    chk("R4 restart full wait", n, 1 + PWR);
  endtask

  task automatic t_priority;
    int n;
    bor_det = 1; mclr_n = 0;
    @(negedge clk);
    chk("R5 bor over mclr", status, 4'b1011);
    bor_det = 0;
    @(negedge clk);
    chk("R3 mclr keeps bor flags", status, 4'b1011);
    mclr_n = 1;
    @(negedge clk);
    count_hold(n);
    chk("R3 wait after mclr in bor", n, PWR);
    mclr_n = 0; wdt_expire = 1;
    @(negedge clk);
    wdt_expire = 0;
    chk("R5 mclr over wdt", status, 4'b1111);
    mclr_n = 1;
    @(negedge clk);
    count_hold(n);
    por_good = 0; bor_det = 1;
    @(negedge clk);
    chk("R5 por over bor", status, 4'b0011);
    por_good = 1; bor_det = 0;
    @(negedge clk);
    count_hold(n);
    chk("R2 wait after por", n, PWR);
  endtask

  task automatic t_flags;
    int n;
    flag_we = 1; flag_wdata = 4'b0000;
    @(negedge clk);
    flag_we = 0;
    chk("R11 write", status, 4'b0000);
    clr_wdt = 1;
    @(negedge clk);
    clr_wdt = 0;
    chk("R10 clear keeps low", status, 4'b0011);
    flag_we = 1; flag_wdata = 4'b1000;
    @(negedge clk);
    flag_we = 0; clr_wdt = 1;
    @(negedge clk);
    clr_wdt = 0;
    chk("R10 clear keeps por", status, 4'b1011);
    mclr_n = 0;
    @(negedge clk);
    flag_we = 1; flag_wdata = 4'b0000;
    @(negedge clk);
    flag_we = 0;
    chk("R11 write ignored held", status, 4'b1111);
    mclr_n = 1;
    @(negedge clk);
    count_hold(n);
    chk("R6 wait", n, 1);
  endtask

  initial begin
    t_power_on();
    t_wake(2'b00, 1'b1, 2'b01, OSC);
    t_mclr_run();
    t_wake(2'b10, 1'b0, 2'b10, 1);
    t_wdt_run();
    t_wdt_sleep(2'b01, OSC);
    t_wdt_sleep(2'b11, 1);
    t_mclr_sleep(2'b00, OSC);
    t_mclr_sleep(2'b10, 1);
    t_wake_ignored();
    t_brownout();
    t_bor_restart();
    t_priority();
    t_flags();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule